// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Detection

This block is the digital serial port of a single-channel telephony codec. An encoder hands it one 8-bit companded sample per frame (either companding law; the port only moves bits). The port sends that word serially, most significant bit first, on a transmit data line timed by an external bit clock. A frame-sync input marks where each frame starts. While the word is on the line, the port raises a drive-enable and pulls an active-low slot indicator low, so that an external bus driver can be switched on. In the same slot it collects eight receive bits from a receive data line and hands them on as a parallel word with a one-cycle valid pulse.

The bit clock and frame sync are slow, asynchronous-looking inputs that the port oversamples with its own fast system clock. The port works out which sync convention is in use from how long frame sync stays high. A sync that is one bit period wide gives short-frame operation. A wider sync gives long-frame operation, in which the line stays driven for as long as sync is held, even past the end of the word. A new sync that arrives partway through a word abandons that word and restarts from the most significant bit.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, txEnable is 0, slotN is 1, txData is 0 and rxValid is 0.
- R2: Frame sync is sampled at each rising edge of bitClk. A frame starts at the first rising edge that sees sync high after a rising edge that saw it low. The MSB of the word is driven from the next rising edge on, and the remaining bits follow MSB-first, one on each later rising edge, for 8 bits in all.
- R3: If sync is low at the rising edge where the MSB is launched (short frame), txEnable falls at the rising edge that follows the eighth bit.
- R4: If sync is still high at that edge (long frame), txEnable stays high after the eighth bit for as long as sync stays high, with txData driven 0. It falls within one system-clock cycle of sync going low, and never before the rising edge that follows the eighth bit.
- R5: slotN is low exactly while txEnable is high. While txEnable is low, txData is 0.
- R6: A txLoad pulse captures txWord into a holding register. The word sent is the one held at the MSB launch edge, and a later txLoad does not alter a word already in flight.
- R7: rxData is sampled at the falling bitClk edge that follows each of the 8 launch edges, MSB first. After the eighth sample, rxWord holds the word and rxValid is high for exactly one system-clock cycle.
- R8: A new frame start during a word in flight restarts transmit and receive from the MSB at the following rising edge. The abandoned receive word is never reported.
- R9: In a long frame, sync falling before the eighth bit does not cut the word short. All 8 bits are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples bitClk and frameSync |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock |
| frameSync | input | 1 | Frame-sync pulse, level sampled on bitClk rising edges |
| txLoad | input | 1 | One-cycle strobe that loads txWord into the holding register |
| txWord | input | 8 | Companded sample from the encoder |
| txData | output | 1 | Serial transmit data, meaningful while txEnable is high |
| txEnable | output | 1 | High while txData is driven |
| slotN | output | 1 | Active-low time-slot indicator for an external bus driver |
| rxData | input | 1 | Serial receive data |
| rxWord | output | 8 | Last complete received word |
| rxValid | output | 1 | One-cycle strobe marking a new rxWord |

## Verification
The hardest situation to reach from the ports is a second frame start that arrives while a word is still shifting. In that case the old transmit word must give way and the partial receive word must be dropped. The stimulus gets there by raising frame sync again for one bit period in the middle of a short frame. At the same time it pulses txLoad with a different value, so that the output shows both that the old word kept going until the restart edge and that the new word is taken from the holding register. The long-frame hold case is reached by keeping sync high for several bit periods beyond the word, and by dropping it before the eighth bit to check that the word is still sent whole.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic rxClear;
    logic rxSample;
    logic rxCommit;
  } portStrobes_t;

endpackage

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitClk,
  input  logic         frameSync,
  output portStrobes_t strobes,
  output logic         txEnable
);

  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  logic             bclkQ;
  logic             bclkRise;
  logic             bclkFall;
  logic             fsSeen;
  logic             pending;
  logic             active;
  logic             hold;
  logic             longMode;
  logic [CNT_W-1:0] bitCnt;
  logic             rxActive;
  logic [CNT_W-1:0] rxCnt;

  assign bclkRise = bitClk & ~bclkQ;
  assign bclkFall = ~bitClk & bclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ    <= 1'b0;
      fsSeen   <= 1'b0;
      pending  <= 1'b0;
      active   <= 1'b0;
      hold     <= 1'b0;
      longMode <= 1'b0;
      bitCnt   <= '0;
      rxActive <= 1'b0;
      rxCnt    <= '0;
    end else begin
      bclkQ <= bitClk;
      if (hold && !frameSync) hold <= 1'b0;
      if (bclkRise) begin
        fsSeen <= frameSync;
        if (pending) begin
          pending  <= 1'b0;
          active   <= 1'b1;
          hold     <= 1'b0;
          bitCnt   <= '0;
          longMode <= frameSync;
          rxActive <= 1'b1;
          rxCnt    <= '0;
        end else begin
          if (frameSync && !fsSeen) pending <= 1'b1;
          if (active) begin
            if (bitCnt == LAST_BIT) begin
              active <= 1'b0;
              if (longMode && frameSync) hold <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
      end
      if (bclkFall && rxActive) begin
        if (rxCnt == LAST_BIT) rxActive <= 1'b0;
        else rxCnt <= rxCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadTx   = bclkRise & pending;
    strobes.shiftTx  = bclkRise & ~pending & active;
    strobes.rxClear  = bclkRise & pending;
    strobes.rxSample = bclkFall & rxActive;
    strobes.rxCommit = bclkFall & rxActive & (rxCnt == LAST_BIT);
  end

  assign txEnable = active | hold;

  // R3
  hold_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> longMode);

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hold && !frameSync) |=> !txEnable);

  // R2
  start_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bclkRise && pending) |=> (txEnable && active && !hold));

endmodule

// File: rtl/pcm_port_dp.sv
module pcm_port_dp
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobes_t         strobes,
  input  logic                 txEnable,
  input  logic                 txLoad,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic                 rxData,
  output logic                 txData,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid
);

  logic [WORD_BITS-1:0] holdWord;
  logic [WORD_BITS-1:0] txShift;
  logic [WORD_BITS-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (txLoad) holdWord <= txWord;
      if (strobes.loadTx) txShift <= holdWord;
      else if (strobes.shiftTx) txShift <= {txShift[WORD_BITS-2:0], 1'b0};
      if (strobes.rxClear) rxShift <= '0;
      else if (strobes.rxSample) rxShift <= {rxShift[WORD_BITS-2:0], rxData};
      if (strobes.rxCommit) rxWord <= {rxShift[WORD_BITS-2:0], rxData};
      rxValid <= strobes.rxCommit;
    end
  end

  assign txData = txEnable & txShift[WORD_BITS-1];

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R6
  tx_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadTx || strobes.shiftTx) |=> $stable(txShift));

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitClk,
  input  logic                 frameSync,
  input  logic                 txLoad,
  input  logic [WORD_BITS-1:0] txWord,
  output logic                 txData,
  output logic                 txEnable,
  output logic                 slotN,
  input  logic                 rxData,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid
);

  portStrobes_t strobes;

  pcm_port_ctrl #(.WORD_BITS(WORD_BITS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitClk    (bitClk),
    .frameSync (frameSync),
    .strobes   (strobes),
    .txEnable  (txEnable)
  );

  pcm_port_dp #(.WORD_BITS(WORD_BITS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txEnable (txEnable),
    .txLoad   (txLoad),
    .txWord   (txWord),
    .rxData   (rxData),
    .txData   (txData),
    .rxWord   (rxWord),
    .rxValid  (rxValid)
  );

  assign slotN = ~txEnable;

endmodule

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitClk = 1'b0;
  logic       frameSync = 1'b0;
  logic       txLoad = 1'b0;
  logic [7:0] txWord = 8'h00;
  logic       rxData = 1'b0;
  logic       txData;
  logic       txEnable;
  logic       slotN;
  logic [7:0] rxWord;
  logic       rxValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [7:0] rxExpQ[$];

  logic       fsPat[32];
  logic       rxPat[32];
  logic       ldPat[32];
  logic [7:0] lwPat[32];
  logic       enExp[32];
  logic       dExp[32];

  always #2 clk = ~clk;

  pcm_serial_port u0 (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .txLoad(txLoad), .txWord(txWord), .txData(txData), .txEnable(txEnable),
    .slotN(slotN), .rxData(rxData), .rxWord(rxWord), .rxValid(rxValid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Scoreboard monitor: pops expected receive words as rxValid appears
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (rxExpQ.size() == 0) begin
        chk("R8", "unexpected rxValid", 1, 0);
      end else begin
        chk("R7", "rxWord", int'(rxWord), int'(rxExpQ.pop_front()));
      end
    end
  end

  // One bit period = 8 system clocks; sync and rx change just after the rise
  task automatic tick(input logic fs, input logic rx, input logic ld, input logic [7:0] lw,
                      output logic oData, output logic oEn, output logic oSlot);
    @(negedge clk); bitClk = 1'b1;
    @(negedge clk); frameSync = fs; rxData = rx; txLoad = ld; txWord = lw;
    @(negedge clk); txLoad = 1'b0;
    @(negedge clk); oData = txData; oEn = txEnable; oSlot = slotN;
    @(negedge clk); bitClk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    logic d, e, s;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 8'h00, d, e, s);
  endtask

  task automatic runPat(input int n, input string req);
    logic d, e, s;
    for (int t = 0; t < n; t++) begin
      tick(fsPat[t], rxPat[t], ldPat[t], lwPat[t], d, e, s);
      chk(req, $sformatf("txEnable period %0d", t), int'(e), int'(enExp[t]));
      chk(req, $sformatf("txData period %0d", t), int'(d), int'(dExp[t]));
      chk("R5", $sformatf("slotN period %0d", t), int'(s), int'(!enExp[t]));
    end
  endtask

  // Single frame with sync held fsLen bit periods (1 = short frame)
  task automatic buildFrame(input logic [7:0] w, input int fsLen, input logic [7:0] rw,
                            output int n);
    n = ((fsLen > 10) ? fsLen : 10) + 2;
    for (int t = 0; t < 32; t++) begin
      fsPat[t] = (t < fsLen);
      rxPat[t] = (t >= 2 && t <= 9) ? rw[9-t] : 1'b0;
      ldPat[t] = (t == 0);
      lwPat[t] = w;
      enExp[t] = (t >= 2 && t <= 9) || (fsLen > 1 && t >= 2 && t < fsLen);
      dExp[t]  = (t >= 2 && t <= 9) ? w[9-t] : 1'b0;
    end
    rxExpQ.push_back(rw);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "txEnable at reset", int'(txEnable), 0);
    chk("R1", "slotN at reset", int'(slotN), 1);
    chk("R1", "txData at reset", int'(txData), 0);
    chk("R1", "rxValid at reset", int'(rxValid), 0);
    rstN = 1'b1;
    idle(3);

    // R2, R3: short frame
    buildFrame(8'hA5, 1, 8'h3C, n);
    runPat(n, "R3");
    idle(2);

    // R2, R4: long frame with sync two periods wide
    buildFrame(8'h96, 2, 8'hC3, n);
    runPat(n, "R2");
    idle(2);

    // R4: sync held well past the word
    buildFrame(8'hFF, 14, 8'h81, n);
    runPat(n, "R4");
    idle(2);

    // R9: long frame with sync dropping before the eighth bit
    buildFrame(8'h01, 4, 8'h7E, n);
    runPat(n, "R9");
    idle(2);

    // R8, R6: restart mid-word, new word loaded while old one shifts
    for (int t = 0; t < 32; t++) begin
      fsPat[t] = (t == 0) || (t == 5);
      rxPat[t] = (t >= 2 && t <= 6) ? 1'b1 : ((t >= 7 && t <= 14) ? 8'h5A >> (14 - t) : 1'b0);
      ldPat[t] = (t == 0) || (t == 3);
      lwPat[t] = (t == 0) ? 8'hB7 : 8'h4D;
      enExp[t] = (t >= 2 && t <= 14);
      if (t >= 2 && t <= 6) dExp[t] = 8'hB7 >> (9 - t);
      else if (t >= 7 && t <= 14) dExp[t] = 8'h4D >> (14 - t);
      else dExp[t] = 1'b0;
    end
    rxExpQ.push_back(8'h5A);
    runPat(17, "R8");
    idle(3);

    chk("R7", "scoreboard drained", rxExpQ.size(), 0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk("WATCHDOG", "run finished", 0, 1);
      summary();
    end
  end

endmodule